// File: doc/BRIEF.md
# Unaligned Word Load/Store Merge Unit

This block performs the data side of partial-word memory instructions for a 32-bit load/store pipe. It takes one request at a time: an operation code, an effective byte address, the current value of the target register (for loads) or the source register (for stores), and the target register index. It always reads the aligned word containing the address. The two low address bits then act as a byte offset that picks the byte lanes to merge.

Loads merge the memory word with the register value, or extend a byte or halfword. The result goes out on a one-cycle write-back strobe. Stores are a read-modify-write: the unit reads the aligned word, replaces the addressed byte lanes from the register, and writes the merged word back over the same memory port. The left and right variants let software assemble or scatter an unaligned word with two instructions. Byte lanes are little-endian: lane k holds bits [8k+7:8k].

Top module: `unaligned_lsu`

## Requirements
- R1: `req_ready_o` is high only while the unit is idle, and it drops in the cycle after a request is accepted. Each access drives `mem_addr_o` with its two low bits zero. The unit holds `mem_valid_o`, address and direction stable until `mem_ready_i` is seen.
- R2: Left load (op code 2): with offset k and aligned word m, the result keeps register bytes below lane 3-k and fills the lanes from 3-k upward with m shifted left by 8*(3-k). At k=3 the result is m.
- R3: Right load (op code 6): the result is m shifted right by 8*k. Its top k bytes come from the register. At k=0 the result is m.
- R4: Left store (op code 10): the written word is the register shifted right by 8*(3-k) in lanes 0..k, with the memory bytes above lane k kept.
- R5: Right store (op code 14): the written word is the register shifted left by 8*k in lanes k..3, with the memory bytes below lane k kept.
- R6: Narrow loads: op 0 gives a sign-extended byte and op 4 a zero-extended byte, both from lane k. Op 1 gives a sign-extended halfword and op 5 a zero-extended halfword, both from the half selected by offset bit 1. Op 3 returns the whole word.
- R7: Stores with op 8 replace lane k with register bits [7:0]. Op 9 replaces the half selected by offset bit 1 with register bits [15:0]. Op 11 writes the whole register.
- R8: A load raises `wb_valid_o` for exactly one cycle, in the cycle after its read handshake, with `wb_idx_o` equal to the request index. A load whose index is 0 raises no strobe.
- R9: A store starts its write in the cycle after its read handshake and raises no write-back strobe. The unit is ready for the next request after the write handshake.
- R10: A right load at byte address A followed by a left load at A+3, chained through the register, yields the four bytes at A..A+3 for every alignment of A. A right store at A and a left store at A+3 of the same value write exactly those four bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Unit idle, request accepted when valid |
| req_op_i | input | 4 | Operation code (see R2-R7) |
| req_addr_i | input | ADDR_W | Effective byte address |
| req_reg_i | input | DATA_W | Register value: merge source for loads, data for stores |
| req_idx_i | input | IDX_W | Target register index for loads |
| mem_valid_o | output | 1 | Memory access request |
| mem_ready_i | input | 1 | Memory accepts access; read data valid this cycle |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | ADDR_W | Word-aligned byte address |
| mem_wdata_o | output | DATA_W | Merged store word |
| mem_rdata_i | input | DATA_W | Aligned read word |
| wb_valid_o | output | 1 | Load result strobe |
| wb_idx_o | output | IDX_W | Load target index |
| wb_data_o | output | DATA_W | Load result |

## Verification
Each left/right load and store is run at all four offsets, using register and memory words whose bytes are all distinct. A wrong shift or a mask that is off by one lane therefore changes a visible byte. Narrow loads read a word with a set top bit in some lanes and a clear one in others, which separates sign extension from zero extension and exposes a wrong lane choice. Chained right/left pairs at every alignment show that the two masks are complementary, since a gap or overlap corrupts the reassembled word or its neighbours. The memory model stalls `mem_ready_i` on a fixed pattern, so both the hold behaviour and the read-then-write order are exercised.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [3:0] {
    OP_LB  = 4'd0,
    OP_LH  = 4'd1,
    OP_LWL = 4'd2,
    OP_LW  = 4'd3,
    OP_LBU = 4'd4,
    OP_LHU = 4'd5,
    OP_LWR = 4'd6,
    OP_SB  = 4'd8,
    OP_SH  = 4'd9,
    OP_SWL = 4'd10,
    OP_SW  = 4'd11,
    OP_SWR = 4'd14
  } lsu_op_e;
endpackage

// File: rtl/lsu_load_merge.sv
module lsu_load_merge import lsu_pkg::*; #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  lsu_op_e           op_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int SH_W = $clog2(DATA_W);
  logic [SH_W-1:0]   sh_l, sh_r, sh_h;
  logic [DATA_W-1:0] ones;
  logic [7:0]        byte_v;
  logic [15:0]       half_v;

  always_comb begin
    ones   = '1;
    sh_l   = SH_W'((NB - 1 - int'(off_i)) * 8);
    sh_r   = SH_W'(int'(off_i) * 8);
    sh_h   = sh_r & ~SH_W'(8);  // halfword lane: drop byte bit
    byte_v = mem_i[sh_r +: 8];
    half_v = mem_i[sh_h +: 16];
    case (op_i)
      OP_LB:   data_o = {{(DATA_W-8){byte_v[7]}}, byte_v};
      OP_LBU:  data_o = {{(DATA_W-8){1'b0}}, byte_v};
      OP_LH:   data_o = {{(DATA_W-16){half_v[15]}}, half_v};
      OP_LHU:  data_o = {{(DATA_W-16){1'b0}}, half_v};
      OP_LWL:  data_o = (mem_i << sh_l) | (reg_i & ~(ones << sh_l));
      OP_LWR:  data_o = (mem_i >> sh_r) | (reg_i & ~(ones >> sh_r));
      default: data_o = mem_i;
    endcase
  end
endmodule

// File: rtl/lsu_store_merge.sv
module lsu_store_merge import lsu_pkg::*; #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  lsu_op_e           op_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int SH_W = $clog2(DATA_W);
  logic [SH_W-1:0]   sh_l, sh_r, sh_h;
  logic [DATA_W-1:0] ones;

  always_comb begin
    ones   = '1;
    sh_r   = SH_W'((NB - 1 - int'(off_i)) * 8);
    sh_l   = SH_W'(int'(off_i) * 8);
    sh_h   = sh_l & ~SH_W'(8);
    data_o = mem_i;
    case (op_i)
      OP_SB:   data_o[sh_l +: 8]  = reg_i[7:0];
      OP_SH:   data_o[sh_h +: 16] = reg_i[15:0];
      OP_SWL:  data_o = (reg_i >> sh_r) | (mem_i & ~(ones >> sh_r));
      OP_SWR:  data_o = (reg_i << sh_l) | (mem_i & ~(ones << sh_l));
      default: data_o = reg_i;
    endcase
  end
endmodule

// File: rtl/unaligned_lsu.sv
module unaligned_lsu import lsu_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [3:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_reg_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              wb_valid_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_RESP} state_e;

  state_e            state_q, state_d;
  lsu_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] reg_q, rdata_q, ld_data, st_data;
  logic [IDX_W-1:0]  idx_q;
  logic [OFF_W-1:0]  off;
  logic              is_store;

  assign off      = addr_q[OFF_W-1:0];
  assign is_store = op_q[3];

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_READ;
      ST_READ:  if (mem_ready_i) state_d = is_store ? ST_WRITE : ST_RESP;
      ST_WRITE: if (mem_ready_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LW;
      addr_q  <= '0;
      reg_q   <= '0;
      idx_q   <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        op_q   <= lsu_op_e'(req_op_i);
        addr_q <= req_addr_i;
        reg_q  <= req_reg_i;
        idx_q  <= req_idx_i;
      end
      if (state_q == ST_READ && mem_ready_i) rdata_q <= mem_rdata_i;
    end
  end

  lsu_load_merge #(.DATA_W(DATA_W)) u_load (
    .op_i(op_q), .off_i(off), .reg_i(reg_q), .mem_i(rdata_q), .data_o(ld_data)
  );

  lsu_store_merge #(.DATA_W(DATA_W)) u_store (
    .op_i(op_q), .off_i(off), .reg_i(reg_q), .mem_i(rdata_q), .data_o(st_data)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_valid_o = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata_o = st_data;
  assign wb_valid_o  = (state_q == ST_RESP) && (idx_q != '0);
  assign wb_idx_o    = idx_q;
  assign wb_data_o   = ld_data;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o) else $error("busy"); // R1
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o))
    else $error("hold"); // R1
  AST_LWL_FULL_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RESP && op_q == OP_LWL && off == OFF_W'(NB-1) |-> wb_data_o == rdata_q)
    else $error("lwl"); // R2
  AST_SWR_FULL_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && op_q == OP_SWR && off == '0 |-> mem_wdata_o == reg_q) else $error("swr"); // R5
  AST_WB_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(mem_valid_o && mem_ready_i && !mem_we_o)) else $error("wb"); // R8
  AST_WB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !wb_valid_o) else $error("wb1"); // R8
  AST_WRITE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_valid_o && mem_we_o) |-> $past(mem_valid_o && mem_ready_i && !mem_we_o))
    else $error("rmw"); // R9
endmodule

// File: tb/unaligned_lsu_tb.sv
module unaligned_lsu_tb;
  logic        clk = 0, rst_ni = 0;
  logic        req_valid_i = 0, req_ready_o;
  logic [3:0]  req_op_i = 0;
  logic [31:0] req_addr_i = 0, req_reg_i = 0;
  logic [4:0]  req_idx_i = 0;
  logic        mem_valid_o, mem_ready_i = 0, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        wb_valid_o;
  logic [4:0]  wb_idx_o;
  logic [31:0] wb_data_o;

  int errors = 0, checks = 0, cyc = 0;
  logic [31:0] mem [16];
  logic        pk_en = 0;
  logic [3:0]  pk_idx = 0;
  logic [31:0] pk_val = 0;

  always #2.5 clk = ~clk;

  unaligned_lsu u_dut (.*, .clk_i(clk));

  assign mem_rdata_i = mem[mem_addr_o[5:2]];
  always @(posedge clk) begin
    if (pk_en) mem[pk_idx] <= pk_val;
    else if (mem_valid_o && mem_ready_i && mem_we_o) mem[mem_addr_o[5:2]] <= mem_wdata_o;
  end
  always @(negedge clk) begin
    cyc++;
    mem_ready_i = (cyc % 3) != 1;
  end

  initial begin
    #(5ns * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic poke(int idx, logic [31:0] val);
    @(negedge clk); pk_en = 1; pk_idx = 4'(idx); pk_val = val;
    @(negedge clk); pk_en = 0;
  endtask

  function automatic logic [7:0] get_byte(logic [5:0] a);
    return mem[a[5:2]][8*a[1:0] +: 8];
  endfunction

  // runs one request; returns last wb data, strobe count, alignment flag
  task automatic run_op(logic [3:0] op, logic [31:0] addr, logic [31:0] rv, logic [4:0] idx,
                        output logic [31:0] res, output int pulses, output logic ok_addr);
    int guard;
    res = 'x; pulses = 0; ok_addr = 1; guard = 0;
    @(negedge clk);
    while (!req_ready_o && guard < 50) begin @(negedge clk); guard++; end
    req_valid_i = 1; req_op_i = op; req_addr_i = addr; req_reg_i = rv; req_idx_i = idx;
    @(negedge clk);
    req_valid_i = 0;
    if (req_ready_o) ok_addr = 0;  // must be busy after accept
    while (!req_ready_o && guard < 50) begin
      if (wb_valid_o) begin
        pulses++; res = wb_data_o;
        if (wb_idx_o != idx) ok_addr = 0;
      end
      if (mem_valid_o && mem_addr_o[1:0] != 2'b00) ok_addr = 0;
      @(negedge clk); guard++;
    end
  endtask

  function automatic logic [31:0] e_lwl(int k, logic [31:0] m, logic [31:0] r);
    case (k)
      0: return {m[7:0], r[23:0]};
      1: return {m[15:0], r[15:0]};
      2: return {m[23:0], r[7:0]};
      default: return m;
    endcase
  endfunction
  function automatic logic [31:0] e_lwr(int k, logic [31:0] m, logic [31:0] r);
    case (k)
      0: return m;
      1: return {r[31:24], m[31:8]};
      2: return {r[31:16], m[31:16]};
      default: return {r[31:8], m[31:24]};
    endcase
  endfunction
  function automatic logic [31:0] e_swl(int k, logic [31:0] m, logic [31:0] r);
    case (k)
      0: return {m[31:8], r[31:24]};
      1: return {m[31:16], r[31:16]};
      2: return {m[31:24], r[31:8]};
      default: return r;
    endcase
  endfunction
  function automatic logic [31:0] e_swr(int k, logic [31:0] m, logic [31:0] r);
    case (k)
      0: return r;
      1: return {r[23:0], m[7:0]};
      2: return {r[15:0], m[15:0]};
      default: return {r[7:0], m[23:0]};
    endcase
  endfunction

  task automatic t_reset;
    chk("R1 reset ready", 32'(req_ready_o), 1);
    chk("R1 reset mem_valid", 32'(mem_valid_o), 0);
    chk("R8 reset wb_valid", 32'(wb_valid_o), 0);
  endtask

  task automatic t_part_loads;
    logic [31:0] res; int p; logic ok;
    poke(2, 32'h11223344);
    for (int k = 0; k < 4; k++) begin
      run_op(4'd2, 32'h08 + 32'(k), 32'hAABBCCDD, 5'd5, res, p, ok);
      chk("R2 lwl", res, e_lwl(k, 32'h11223344, 32'hAABBCCDD));
      chk("R8 lwl strobe", 32'(p), 1);
      chk("R1 aligned", 32'(ok), 1);
      run_op(4'd6, 32'h08 + 32'(k), 32'hAABBCCDD, 5'd7, res, p, ok);
      chk("R3 lwr", res, e_lwr(k, 32'h11223344, 32'hAABBCCDD));
      chk("R1 aligned", 32'(ok), 1);
    end
  endtask

  task automatic t_part_stores;
    logic [31:0] res; int p; logic ok;
    for (int k = 0; k < 4; k++) begin
      poke(3, 32'h55667788);
      run_op(4'd10, 32'h0C + 32'(k), 32'h99AABBCC, 5'd3, res, p, ok);
      chk("R4 swl", mem[3], e_swl(k, 32'h55667788, 32'h99AABBCC));
      chk("R9 no strobe", 32'(p), 0);
      poke(3, 32'h55667788);
      run_op(4'd14, 32'h0C + 32'(k), 32'h99AABBCC, 5'd3, res, p, ok);
      chk("R5 swr", mem[3], e_swr(k, 32'h55667788, 32'h99AABBCC));
      chk("R1 aligned", 32'(ok), 1);
    end
  endtask

  task automatic t_narrow_loads;
    logic [31:0] res, w; logic [7:0] b; logic [15:0] h; int p; logic ok;
    w = 32'h80F17F02;
    poke(4, w);
    for (int k = 0; k < 4; k++) begin
      b = w[8*k +: 8];
      run_op(4'd0, 32'h10 + 32'(k), 32'hFFFF_FFFF, 5'd1, res, p, ok);
      chk("R6 lb", res, {{24{b[7]}}, b});
      run_op(4'd4, 32'h10 + 32'(k), 32'hFFFF_FFFF, 5'd1, res, p, ok);
      chk("R6 lbu", res, {24'h0, b});
    end
    for (int k = 0; k < 2; k++) begin
      h = w[16*k +: 16];
      run_op(4'd1, 32'h10 + 32'(2*k), 32'h0, 5'd2, res, p, ok);
      chk("R6 lh", res, {{16{h[15]}}, h});
      run_op(4'd5, 32'h10 + 32'(2*k), 32'h0, 5'd2, res, p, ok);
      chk("R6 lhu", res, {16'h0, h});
    end
    run_op(4'd3, 32'h10, 32'h0, 5'd2, res, p, ok);
    chk("R6 lw", res, w);
  endtask

  task automatic t_narrow_stores;
    logic [31:0] res, e; int p; logic ok;
    for (int k = 0; k < 4; k++) begin
      poke(5, 32'h01234567);
      run_op(4'd8, 32'h14 + 32'(k), 32'hDEADBEEF, 5'd0, res, p, ok);
      e = 32'h01234567; e[8*k +: 8] = 8'hEF;
      chk("R7 sb", mem[5], e);
    end
    for (int k = 0; k < 2; k++) begin
      poke(5, 32'h01234567);
      run_op(4'd9, 32'h14 + 32'(2*k), 32'hDEADBEEF, 5'd0, res, p, ok);
      e = 32'h01234567; e[16*k +: 16] = 16'hBEEF;
      chk("R7 sh", mem[5], e);
    end
    run_op(4'd11, 32'h14, 32'hCAFEF00D, 5'd9, res, p, ok);
    chk("R7 sw", mem[5], 32'hCAFEF00D);
    chk("R9 sw no strobe", 32'(p), 0);
  endtask

  task automatic t_zero_dest;
    logic [31:0] res; int p; logic ok;
    run_op(4'd3, 32'h10, 32'h0, 5'd0, res, p, ok);
    chk("R8 idx0 no strobe", 32'(p), 0);
    run_op(4'd2, 32'h0B, 32'h0, 5'd0, res, p, ok);
    chk("R8 idx0 lwl no strobe", 32'(p), 0);
  endtask

  task automatic t_pairs;
    logic [31:0] r, exp; int p; logic ok;
    poke(8, 32'hA3A2A1A0);
    poke(9, 32'hB3B2B1B0);
    for (int k = 0; k < 4; k++) begin
      exp = {get_byte(6'(32+k+3)), get_byte(6'(32+k+2)), get_byte(6'(32+k+1)), get_byte(6'(32+k))};
      run_op(4'd6, 32'h20 + 32'(k), 32'h5A5A5A5A, 5'd4, r, p, ok);
      run_op(4'd2, 32'h23 + 32'(k), r, 5'd4, r, p, ok);
      chk("R10 load pair", r, exp);
    end
    for (int k = 0; k < 4; k++) begin
      poke(10, 32'h0); poke(11, 32'h0);
      run_op(4'd14, 32'h28 + 32'(k), 32'h44332211, 5'd0, r, p, ok);
      run_op(4'd10, 32'h2B + 32'(k), 32'h44332211, 5'd0, r, p, ok);
      exp = {get_byte(6'(40+k+3)), get_byte(6'(40+k+2)), get_byte(6'(40+k+1)), get_byte(6'(40+k))};
      chk("R10 store pair", exp, 32'h44332211);
      chk("R10 store pair neighbours", (mem[10] & ~(32'hFFFFFFFF << 8*k)) | (k == 0 ? 32'h0 : mem[11] & (32'hFFFFFFFF << 8*k)), 32'h0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    t_part_loads();
    t_part_stores();
    t_narrow_loads();
    t_narrow_stores();
    t_zero_dest();
    t_pairs();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule